// File: doc/BRIEF.md
# Dual-Host Bus Switch Control Registers

This block holds two mirrored 16-bit control/status registers for a switch that hands one shared bus between two processors, host A and host B. Each host has its own register with a simple write port (write strobe, two byte enables and write data), a read data output that always shows the current register, and its own interrupt request line. A host uses its register to see the state of the switch and the shared bus, to ring a doorbell that interrupts the other host, and to pulse an initialize line on the shared bus while the switch is on its side.

The switch arbiter reports the switch position and pulses a timeout input whenever the watchdog moved the switch. The shared bus power-warning line is mirrored into both registers. The doorbell is cross-coupled: the send bit of one host reads as the receive bit of the other. A host interrupt is raised on the rising edge of (enable AND receive) and stays high until that host acknowledges it.

Top module: `dualhost_swctl`

## Requirements
- R1: After reset every register bit except the two status mirrors (bit 14 and bit 13) reads 0, both interrupt lines are low and `bus_init` is low.
- R2: Bit 14 of both registers equals `bus_aclo`; bit 13 of both registers is 1 whenever `sw_pos` is not 2'b00 (neutral). Position codes: 2'b01 means side A holds the bus, 2'b10 side B, 2'b11 neither side.
- R3: A cycle with `tmo_evt` high sets bit 15 in both registers. A write with at least one byte enable set clears bit 15 of the writer's register only; a timeout in the same cycle as the write leaves bit 15 set.
- R4: Bit 11 (send) is written from data bit 11 when byte enable bit 1 (bits 15:8) is set; bit 12 of each register always reads the other host's bit 11.
- R5: A host's interrupt line goes high one cycle after (bit 10 AND bit 12) of its register rises, and stays high as a level.
- R6: A one-cycle acknowledge lowers the interrupt line at the next edge, and it is not raised again until bit 10 or bit 12 has fallen and risen again.
- R7: A host's clear input zeroes its bits 15, 11, 10 and 9 and its interrupt line, stopping any pulse it started, and leaves the other register untouched.
- R8: Writing 1 to bit 9 (byte enable bit 1) while the switch position names the writer's side drives `bus_init` high for exactly CLK_MHZ*INIT_US cycles, starting at the write edge, and bit 9 reads 1 for that time; the same write from the other side has no effect.
- R9: Bits 15 to 12 ignore written data, byte enable bit 0 alters no stored bit, and bits 8 to 0 always read 0.
- R10: Writing 1 to bit 9 while that host's pulse is running does not restart it; the pulse ends on its original schedule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset (power up/down) |
| sw_pos | input | 2 | Switch position code |
| tmo_evt | input | 1 | One-cycle pulse: the watchdog moved the switch |
| bus_aclo | input | 1 | Shared bus power-warning line |
| a_wr_en | input | 1 | Host A write strobe |
| a_be | input | 2 | Host A byte enables (bit 1 = high byte) |
| a_wdata | input | 16 | Host A write data |
| a_clr | input | 1 | Host A bus reset/start clear |
| a_ack | input | 1 | Host A interrupt acknowledge |
| a_rdata | output | 16 | Host A register contents |
| a_irq | output | 1 | Host A interrupt request |
| b_wr_en | input | 1 | Host B write strobe |
| b_be | input | 2 | Host B byte enables (bit 1 = high byte) |
| b_wdata | input | 16 | Host B write data |
| b_clr | input | 1 | Host B bus reset/start clear |
| b_ack | input | 1 | Host B interrupt acknowledge |
| b_rdata | output | 16 | Host B register contents |
| b_irq | output | 1 | Host B interrupt request |
| bus_init | output | 1 | Initialize pulse on the shared bus |

## Verification
The bench targets the interrupt edge: after an acknowledge it holds enable and receive high for several cycles, where a level-triggered design would raise the line again, and then toggles enable to show a fresh rise is honoured one cycle late, not zero or two. It writes a timeout and a register write into the same cycle, where a design giving the write priority would lose the flag, and checks that a low-byte-only write clears the flag while leaving the send bit alone. It counts the initialize pulse to the exact cycle across a second start request in mid-pulse, which a restarting timer would stretch by hundreds of cycles, and tries a start from the side that does not hold the switch. A full-word write of ones into the read-only bits must leave only the status mirrors and the send bit visible.

// File: rtl/swctl_pkg.sv
package swctl_pkg;
  localparam int unsigned CSR_W = 16;

  // bit positions inside each host register
  localparam int unsigned BIT_TMO  = 15;
  localparam int unsigned BIT_PWR  = 14;
  localparam int unsigned BIT_ENG  = 13;
  localparam int unsigned BIT_RCV  = 12;
  localparam int unsigned BIT_SEND = 11;
  localparam int unsigned BIT_IE   = 10;
  localparam int unsigned BIT_INIT = 9;

  typedef enum logic [1:0] {
    POS_NEUTRAL = 2'b00,
    POS_SIDE_A  = 2'b01,
    POS_SIDE_B  = 2'b10,
    POS_NONE    = 2'b11
  } swpos_e;

  // initialize pulse length in clock cycles
  function automatic int unsigned pulse_cycles(input int unsigned clk_mhz,
                                               input int unsigned width_us);
    return clk_mhz * width_us;
  endfunction

  // true when the switch position names this side
  function automatic logic side_owns(input logic [1:0] pos, input int unsigned side);
    return (side == 0) ? (pos == POS_SIDE_A) : (pos == POS_SIDE_B);
  endfunction
endpackage

// File: rtl/swctl_init_timer.sv
module swctl_init_timer #(
  parameter int unsigned CYCLES = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic start,
  output logic busy
);
  localparam int unsigned CNT_W = $clog2(CYCLES + 1);

  logic [CNT_W-1:0] cnt;
  logic             load;

  assign busy = (cnt != '0);
  assign load = start && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (clr)     cnt <= '0;
    else if (load)    cnt <= CNT_W'(CYCLES);
    else if (busy)    cnt <= cnt - 1'b1;
  end

  // R8: an accepted start loads the full pulse length
  a_r8_full_length: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !clr) |=> (cnt == CNT_W'(CYCLES)));

  // R10: a running pulse only counts down, even under a new start
  a_r10_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !clr) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/swctl_irq_edge.sv
module swctl_irq_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  input  logic rcv,
  input  logic ack,
  output logic irq,
  output logic rise
);
  logic and_now;
  logic and_prev;

  assign and_now = en && rcv;
  assign rise    = and_now && !and_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      and_prev <= 1'b0;
      irq      <= 1'b0;
    end else begin
      and_prev <= and_now;
      if (clr)       irq <= 1'b0;
      else if (rise) irq <= 1'b1;
      else if (ack)  irq <= 1'b0;
    end
  end

  // R5: the line only goes up after a detected rise
  a_r5_from_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(rise));

  // R6: acknowledge without a new rise drops the line
  a_r6_ack_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !rise) |=> !irq);

  // R6: a low line stays low without a fresh rise
  a_r6_no_refire: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq && !rise) |=> !irq);
endmodule

// File: rtl/swctl_host_reg.sv
module swctl_host_reg
  import swctl_pkg::*;
#(
  parameter int unsigned SIDE        = 0,
  parameter int unsigned INIT_CYCLES = 1000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             wr_en,
  input  logic [1:0]       be,
  input  logic [CSR_W-1:0] wdata,
  input  logic             ack,
  input  logic [1:0]       pos,
  input  logic             tmo_evt,
  input  logic             aclo,
  input  logic             rcv_in,
  output logic             send_out,
  output logic             init_busy,
  output logic             irq,
  output logic [CSR_W-1:0] rdata
);
  logic tmo_flag;
  logic send_q;
  logic ie_q;
  logic hi_wr;
  logic any_wr;
  logic owner;
  logic start_req;
  logic rise_evt;
  logic unused_wbits;

  assign hi_wr     = wr_en && be[1];
  assign any_wr    = wr_en && (be != 2'b00);
  assign owner     = side_owns(pos, SIDE);
  assign start_req = hi_wr && wdata[BIT_INIT] && owner;
  assign unused_wbits = ^{wdata[15:12], wdata[8:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmo_flag <= 1'b0;
      send_q   <= 1'b0;
      ie_q     <= 1'b0;
    end else if (clr) begin
      tmo_flag <= 1'b0;
      send_q   <= 1'b0;
      ie_q     <= 1'b0;
    end else begin
      if (tmo_evt)     tmo_flag <= 1'b1;
      else if (any_wr) tmo_flag <= 1'b0;
      if (hi_wr) begin
        send_q <= wdata[BIT_SEND];
        ie_q   <= wdata[BIT_IE];
      end
    end
  end

  swctl_init_timer #(.CYCLES(INIT_CYCLES)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (clr),
    .start (start_req),
    .busy  (init_busy)
  );

  swctl_irq_edge u_irq (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (clr),
    .en    (ie_q),
    .rcv   (rcv_in),
    .ack   (ack),
    .irq   (irq),
    .rise  (rise_evt)
  );

  always_comb begin
    rdata           = '0;
    rdata[BIT_TMO]  = tmo_flag;
    rdata[BIT_PWR]  = aclo;
    rdata[BIT_ENG]  = (pos != POS_NEUTRAL);
    rdata[BIT_RCV]  = rcv_in;
    rdata[BIT_SEND] = send_q;
    rdata[BIT_IE]   = ie_q;
    rdata[BIT_INIT] = init_busy;
  end

  assign send_out = send_q;

  // R3: a timeout event always leaves the flag set
  a_r3_tmo_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_evt && !clr) |=> rdata[BIT_TMO]);

  // R3: a write without a timeout clears the flag
  a_r3_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (any_wr && !tmo_evt) |=> !rdata[BIT_TMO]);

  // R8: no pulse starts from the side that does not hold the switch
  a_r8_owner_only: assert property (@(posedge clk) disable iff (!rst_n)
    (!init_busy && !owner) |=> !init_busy);

  // R7: clear empties the writable bits
  a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!send_q && !ie_q && !init_busy && !irq));

  // R9: undefined bits never read as one
  a_r9_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rdata[8:0] == 9'd0);
endmodule

// File: rtl/dualhost_swctl.sv
module dualhost_swctl
  import swctl_pkg::*;
#(
  parameter int unsigned CLK_MHZ = 100,
  parameter int unsigned INIT_US = 10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  sw_pos,
  input  logic        tmo_evt,
  input  logic        bus_aclo,
  input  logic        a_wr_en,
  input  logic [1:0]  a_be,
  input  logic [15:0] a_wdata,
  input  logic        a_clr,
  input  logic        a_ack,
  output logic [15:0] a_rdata,
  output logic        a_irq,
  input  logic        b_wr_en,
  input  logic [1:0]  b_be,
  input  logic [15:0] b_wdata,
  input  logic        b_clr,
  input  logic        b_ack,
  output logic [15:0] b_rdata,
  output logic        b_irq,
  output logic        bus_init
);
  localparam int unsigned NHOST       = 2;
  localparam int unsigned INIT_CYCLES = pulse_cycles(CLK_MHZ, INIT_US);

  logic             wr_en_v [NHOST];
  logic [1:0]       be_v    [NHOST];
  logic [CSR_W-1:0] wdata_v [NHOST];
  logic             clr_v   [NHOST];
  logic             ack_v   [NHOST];
  logic [CSR_W-1:0] rdata_v [NHOST];
  logic             irq_v   [NHOST];
  logic             send_v  [NHOST];
  logic             busy_v  [NHOST];

  assign wr_en_v[0] = a_wr_en;  assign wr_en_v[1] = b_wr_en;
  assign be_v[0]    = a_be;     assign be_v[1]    = b_be;
  assign wdata_v[0] = a_wdata;  assign wdata_v[1] = b_wdata;
  assign clr_v[0]   = a_clr;    assign clr_v[1]   = b_clr;
  assign ack_v[0]   = a_ack;    assign ack_v[1]   = b_ack;

  for (genvar h = 0; h < NHOST; h++) begin : g_host
    swctl_host_reg #(
      .SIDE        (h),
      .INIT_CYCLES (INIT_CYCLES)
    ) u_reg (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (clr_v[h]),
      .wr_en     (wr_en_v[h]),
      .be        (be_v[h]),
      .wdata     (wdata_v[h]),
      .ack       (ack_v[h]),
      .pos       (sw_pos),
      .tmo_evt   (tmo_evt),
      .aclo      (bus_aclo),
      .rcv_in    (send_v[NHOST-1-h]),
      .send_out  (send_v[h]),
      .init_busy (busy_v[h]),
      .irq       (irq_v[h]),
      .rdata     (rdata_v[h])
    );
  end

  assign a_rdata  = rdata_v[0];
  assign b_rdata  = rdata_v[1];
  assign a_irq    = irq_v[0];
  assign b_irq    = irq_v[1];
  assign bus_init = busy_v[0] || busy_v[1];

  // R4: a send write shows up as receive on the opposite register
  a_r4_cross: assert property (@(posedge clk) disable iff (!rst_n)
    (a_wr_en && a_be[1] && !a_clr) |=> (b_rdata[BIT_RCV] == $past(a_wdata[BIT_SEND])));
endmodule

// File: tb/dualhost_swctl_bench.sv
`timescale 1ns/1ps
module dualhost_swctl_bench;
  localparam int unsigned CLK_MHZ = 100;
  localparam int unsigned INIT_US = 10;
  localparam int NPULSE = CLK_MHZ * INIT_US;

  typedef struct {
    string       req;
    int          kind;   // 0 a_rdata, 1 b_rdata, 2 a_irq, 3 b_irq, 4 bus_init
    logic [15:0] mask;
    logic [15:0] exp;
  } item_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] sw_pos = 2'b00;
  logic tmo_evt = 1'b0, bus_aclo = 1'b0;
  logic a_wr_en = 1'b0, b_wr_en = 1'b0;
  logic [1:0] a_be = 2'b00, b_be = 2'b00;
  logic [15:0] a_wdata = '0, b_wdata = '0;
  logic a_clr = 1'b0, b_clr = 1'b0, a_ack = 1'b0, b_ack = 1'b0;
  logic [15:0] a_rdata, b_rdata;
  logic a_irq, b_irq, bus_init;

  item_t q[$];
  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  dualhost_swctl #(.CLK_MHZ(CLK_MHZ), .INIT_US(INIT_US)) u_dualhost_swctl (
    .clk(clk), .rst_n(rst_n), .sw_pos(sw_pos), .tmo_evt(tmo_evt), .bus_aclo(bus_aclo),
    .a_wr_en(a_wr_en), .a_be(a_be), .a_wdata(a_wdata), .a_clr(a_clr), .a_ack(a_ack),
    .a_rdata(a_rdata), .a_irq(a_irq),
    .b_wr_en(b_wr_en), .b_be(b_be), .b_wdata(b_wdata), .b_clr(b_clr), .b_ack(b_ack),
    .b_rdata(b_rdata), .b_irq(b_irq), .bus_init(bus_init)
  );

  function automatic logic [15:0] observe(input int kind);
    case (kind)
      0: return a_rdata;
      1: return b_rdata;
      2: return {15'd0, a_irq};
      3: return {15'd0, b_irq};
      default: return {15'd0, bus_init};
    endcase
  endfunction

  // monitor: compares every queued expectation at the falling edge
  always @(negedge clk) begin
    while (q.size() > 0) begin
      item_t it;
      logic [15:0] act;
      it = q.pop_front();
      act = observe(it.kind) & it.mask;
      compared++;
      if (act !== it.exp) begin
        mismatched++;
        $display("FAIL %s kind=%0d actual=%h expected=%h", it.req, it.kind, act, it.exp);
      end
    end
  end

  task automatic expect_val(input string req, input int kind,
                            input logic [15:0] mask, input logic [15:0] exp);
    item_t it;
    it.req = req; it.kind = kind; it.mask = mask; it.exp = exp;
    q.push_back(it);
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic wr(input int h, input logic [1:0] be, input logic [15:0] d);
    if (h == 0) begin a_wr_en = 1'b1; a_be = be; a_wdata = d; end
    else        begin b_wr_en = 1'b1; b_be = be; b_wdata = d; end
    tick(1);
    a_wr_en = 1'b0; b_wr_en = 1'b0;
  endtask

  initial begin
    tick(3);
    rst_n = 1'b1;
    expect_val("R1", 0, 16'hFFFF, 16'h0000);
    expect_val("R1", 1, 16'hFFFF, 16'h0000);
    expect_val("R1", 2, 16'h0001, 16'h0000);
    expect_val("R1", 4, 16'h0001, 16'h0000);
    tick(1);

    sw_pos = 2'b01; bus_aclo = 1'b1; #1;
    expect_val("R2", 0, 16'hE000, 16'h6000);
    expect_val("R2", 1, 16'hE000, 16'h6000);
    tick(1);

    wr(0, 2'b10, 16'h0800);
    expect_val("R4", 0, 16'h1E00, 16'h0800);
    expect_val("R4", 1, 16'h1E00, 16'h1000);

    wr(1, 2'b10, 16'h0400);
    expect_val("R5 latency", 3, 16'h0001, 16'h0000);
    tick(1);
    expect_val("R5", 3, 16'h0001, 16'h0001);
    expect_val("R5", 2, 16'h0001, 16'h0000);

    b_ack = 1'b1; tick(1); b_ack = 1'b0;
    expect_val("R6 ack", 3, 16'h0001, 16'h0000);
    tick(5);
    expect_val("R6 no refire", 3, 16'h0001, 16'h0000);
    wr(1, 2'b10, 16'h0000);
    wr(1, 2'b10, 16'h0400);
    tick(1);
    expect_val("R6 fresh rise", 3, 16'h0001, 16'h0001);
    b_ack = 1'b1; tick(1); b_ack = 1'b0;
    expect_val("R6 ack2", 3, 16'h0001, 16'h0000);

    tmo_evt = 1'b1; tick(1); tmo_evt = 1'b0;
    expect_val("R3 set", 0, 16'h8000, 16'h8000);
    expect_val("R3 set", 1, 16'h8000, 16'h8000);
    wr(0, 2'b01, 16'hFFFF);
    expect_val("R3 low byte clears", 0, 16'h8E00, 16'h0800);
    expect_val("R3 other kept", 1, 16'h8000, 16'h8000);
    expect_val("R9 low bits", 0, 16'h01FF, 16'h0000);

    b_wr_en = 1'b1; b_be = 2'b10; b_wdata = 16'h0400; tmo_evt = 1'b1;
    tick(1);
    b_wr_en = 1'b0; tmo_evt = 1'b0;
    expect_val("R3 same cycle", 1, 16'h8000, 16'h8000);
    expect_val("R3 same cycle", 0, 16'h8000, 16'h8000);

    wr(0, 2'b11, 16'hF8FF);
    expect_val("R9 read-only", 0, 16'hFFFF, 16'h6800);

    wr(1, 2'b10, 16'h0600);
    expect_val("R8 not owner", 4, 16'h0001, 16'h0000);
    expect_val("R8 not owner", 1, 16'h0600, 16'h0400);

    wr(0, 2'b10, 16'h0A00);
    expect_val("R8 start", 4, 16'h0001, 16'h0001);
    expect_val("R8 start", 0, 16'h0200, 16'h0200);
    tick(498);
    wr(0, 2'b10, 16'h0A00);
    tick(NPULSE - 1 - 499);
    expect_val("R10 last cycle", 4, 16'h0001, 16'h0001);
    expect_val("R8 last cycle", 0, 16'h0200, 16'h0200);
    tick(1);
    expect_val("R10 ends", 4, 16'h0001, 16'h0000);
    expect_val("R8 ends", 0, 16'h0200, 16'h0000);

    wr(0, 2'b10, 16'h0C00);
    tmo_evt = 1'b1; tick(1); tmo_evt = 1'b0;
    a_clr = 1'b1; tick(1); a_clr = 1'b0;
    expect_val("R7 cleared", 0, 16'h8E00, 16'h0000);
    expect_val("R7 other", 1, 16'h9C00, 16'h8400);
    expect_val("R7 irq", 2, 16'h0001, 16'h0000);

    sw_pos = 2'b00; bus_aclo = 1'b0; #1;
    expect_val("R2 neutral", 0, 16'h6000, 16'h0000);
    expect_val("R2 neutral", 1, 16'h6000, 16'h0000);
    tick(2);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule